// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block sits beside an 8-bit processor core and takes over at instruction boundaries when an interrupt must be serviced. At each boundary strobe it looks at a latched non-maskable request and a level maskable request. It picks at most one of them, with the non-maskable one first. It then runs the response. The response saves the program counter on the stack through a byte-wide memory port. It works out the new program counter and hands the core its updated stack pointer, enable flags and internal WZ value.

Maskable requests are served in one of three modes. The first mode takes a single restart opcode from the acknowledge bus. The second mode jumps to a fixed vector. The third mode forms a table pointer from the I register and the acknowledge byte, and reads the target from memory. The block also tells the core to leave its halted state when it takes an interrupt. The core stalls while `busy_o` is high and loads `pc_o`, `wz_o` and `sp_o` in the cycle `done_o` is high.

Top module: `irq_resp_seq`

## Requirements
- R1: A rising edge on `nmi_i` is held pending until it is taken. At a boundary (`boundary_i` high while idle), a pending edge is always taken, even when a maskable request is present. Only one interrupt is taken per boundary, and taking it clears the pending edge.
- R2: In the cycle after an interrupt is taken, `iff_we_o` pulses with `iff1_o`=0. `iff2_o` equals the `iff1_i` value seen at the boundary for a non-maskable interrupt, and 0 for a maskable one.
- R3: A non-maskable interrupt ends with `pc_o`=0x0066.
- R4: A maskable interrupt is taken only if `int_req_i`=1, `iff1_i`=1 and `skip_int_i`=0 at the boundary. Otherwise no memory request, no `inta_o` and no `done_o` follow.
- R5: The push writes PC[15:8] to SP-1 first and then PC[7:0] to SP-2, with 16-bit wrap. `sp_o`=SP-2 at `done_o`.
- R6: Mode 1 (`int_mode_i`=2'b01) ends with `pc_o`=0x0038.
- R7: Mode 2 (`int_mode_i`=2'b10 or 2'b11) forms pointer P={I, byte}, where byte is `ack_data_i` if `ack_valid_i`=1 and 0x00 otherwise. It reads the low byte at P and the high byte at P+1, and loads that word into `pc_o`.
- R8: Mode 0 (`int_mode_i`=2'b00) with an opcode of the form 11ttt111 ends with `pc_o`=ttt*8. Any other opcode raises `err_o` with `done_o` and ends with `pc_o`=0x0038.
- R9: At `done_o`, `wz_o` equals `pc_o`.
- R10: `halt_clr_o` pulses in the cycle after acceptance exactly when `halted_i` was high at the boundary.
- R11: For a maskable interrupt, `inta_o` is high for exactly the cycle after acceptance, and the acknowledge byte is sampled in that cycle. A non-maskable interrupt produces no `inta_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| skip_int_i | input | 1 | Last instruction forbids a maskable interrupt now |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| int_req_i | input | 1 | Maskable request, level |
| int_mode_i | input | 2 | Maskable interrupt mode |
| iff1_i | input | 1 | Current enable flip-flop 1 |
| halted_i | input | 1 | Core is halted |
| ireg_i | input | 8 | I register |
| pc_i | input | 16 | Program counter to save |
| sp_i | input | 16 | Stack pointer |
| ack_valid_i | input | 1 | A device drives the acknowledge byte |
| ack_data_i | input | 8 | Acknowledge byte |
| inta_o | output | 1 | Acknowledge cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid with `mem_ready_i` |
| mem_ready_i | input | 1 | Memory completes the request this cycle |
| busy_o | output | 1 | Response in progress |
| done_o | output | 1 | Response finished, results valid |
| pc_o | output | 16 | New program counter |
| wz_o | output | 16 | New WZ value |
| sp_o | output | 16 | New stack pointer |
| iff_we_o | output | 1 | Load enable flip-flops |
| iff1_o | output | 1 | New IFF1 |
| iff2_o | output | 1 | New IFF2 |
| halt_clr_o | output | 1 | Leave halted state |
| err_o | output | 1 | Mode 0 opcode was not a restart |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 16-bit address, and the 0x0066 and 0x0038 vectors. With these values, every I-register and acknowledge-byte pair is a legal mode 2 pointer. That brings the carry of P+1 across the byte boundary within reach, and so is a stack pointer of 0x0001, where the push wraps to 0xFFFF. The memory model holds back its ready at random, so each push and table step is seen both with and without wait states.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_ACK     = 3'd1,
        S_PUSH_HI = 3'd2,
        S_PUSH_LO = 3'd3,
        S_RD_LO   = 3'd4,
        S_RD_HI   = 3'd5,
        S_DONE    = 3'd6
    } seq_state_e;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic take_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = nmi_i;
        e_d.pend = (e_q.pend && !take_i) || (nmi_i && !e_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign pend_o = e_q.pend;

    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !take_i) |=> pend_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic idle_i,
    input  logic boundary_i,
    input  logic nmi_pend_i,
    input  logic int_req_i,
    input  logic iff1_i,
    input  logic skip_i,
    output logic take_nmi_o,
    output logic take_int_o
);
    logic at_edge;

    always_comb begin
        at_edge    = idle_i && boundary_i;
        take_nmi_o = at_edge && nmi_pend_i;
        take_int_o = at_edge && !nmi_pend_i && int_req_i && iff1_i && !skip_i;
    end
endmodule

// File: rtl/irq_vector.sv
module irq_vector #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] IM1_VEC = 16'h0038
) (
    input  logic [1:0]      mode_i,
    input  logic [DW-1:0]   byte_i,
    output logic [2*DW-1:0] tgt_o,
    output logic            tbl_o,
    output logic            err_o
);
    localparam int AW = 2 * DW;

    logic is_rst;

    always_comb begin
        is_rst = (byte_i[7:6] == 2'b11) && (byte_i[2:0] == 3'b111);
        tgt_o  = IM1_VEC;
        tbl_o  = 1'b0;
        err_o  = 1'b0;
        case (mode_i)
            2'b00: begin
                if (is_rst) tgt_o = {{(AW-6){1'b0}}, byte_i[5:3], 3'b000};
                else        err_o = 1'b1;
            end
            2'b01:   tgt_o = IM1_VEC;
            default: tbl_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
    import irq_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] NMI_VEC = 16'h0066,
    parameter logic [2*DW-1:0] IM1_VEC = 16'h0038
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             skip_int_i,
    input  logic             nmi_i,
    input  logic             int_req_i,
    input  logic [1:0]       int_mode_i,
    input  logic             iff1_i,
    input  logic             halted_i,
    input  logic [DW-1:0]    ireg_i,
    input  logic [2*DW-1:0]  pc_i,
    input  logic [2*DW-1:0]  sp_i,
    input  logic             ack_valid_i,
    input  logic [DW-1:0]    ack_data_i,
    output logic             inta_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [2*DW-1:0]  mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    input  logic             mem_ready_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [2*DW-1:0]  pc_o,
    output logic [2*DW-1:0]  wz_o,
    output logic [2*DW-1:0]  sp_o,
    output logic             iff_we_o,
    output logic             iff1_o,
    output logic             iff2_o,
    output logic             halt_clr_o,
    output logic             err_o
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        seq_state_e    st;
        logic          is_nmi;
        logic [1:0]    mode;
        logic          tbl;
        logic          err;
        logic          iff_we;
        logic          iff2;
        logic          hclr;
        logic [DW-1:0] ireg;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] tgt;
        logic [AW-1:0] ptr;
    } seq_t;

    seq_t r_d, r_q;

    logic          nmi_pend, take_nmi, take_int, idle;
    logic [DW-1:0] bus_byte;
    logic [AW-1:0] vec_tgt;
    logic          vec_tbl, vec_err;

    assign idle     = (r_q.st == S_IDLE);
    assign bus_byte = ack_valid_i ? ack_data_i : '0;

    irq_nmi_edge u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .take_i (take_nmi),
        .pend_o (nmi_pend)
    );

    irq_arbiter u_arb (
        .idle_i     (idle),
        .boundary_i (boundary_i),
        .nmi_pend_i (nmi_pend),
        .int_req_i  (int_req_i),
        .iff1_i     (iff1_i),
        .skip_i     (skip_int_i),
        .take_nmi_o (take_nmi),
        .take_int_o (take_int)
    );

    irq_vector #(.DW(DW), .IM1_VEC(IM1_VEC)) u_vec (
        .mode_i (r_q.mode),
        .byte_i (bus_byte),
        .tgt_o  (vec_tgt),
        .tbl_o  (vec_tbl),
        .err_o  (vec_err)
    );

    always_comb begin
        r_d        = r_q;
        r_d.iff_we = 1'b0;
        r_d.hclr   = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                r_d.err = 1'b0;
                if (take_nmi || take_int) begin
                    r_d.pc     = pc_i;
                    r_d.sp     = sp_i;
                    r_d.ireg   = ireg_i;
                    r_d.mode   = int_mode_i;
                    r_d.iff_we = 1'b1;
                    r_d.hclr   = halted_i;
                    r_d.is_nmi = take_nmi;
                    r_d.tbl    = 1'b0;
                    if (take_nmi) begin
                        r_d.iff2 = iff1_i;
                        r_d.tgt  = NMI_VEC;
                        r_d.st   = S_PUSH_HI;
                    end else begin
                        r_d.iff2 = 1'b0;
                        r_d.st   = S_ACK;
                    end
                end
            end
            S_ACK: begin
                r_d.tgt = vec_tgt;
                r_d.tbl = vec_tbl;
                r_d.err = vec_err;
                r_d.ptr = {r_q.ireg, bus_byte};
                r_d.st  = S_PUSH_HI;
            end
            S_PUSH_HI: begin
                if (mem_ready_i) begin
                    r_d.sp = r_q.sp - 1'b1;
                    r_d.st = S_PUSH_LO;
                end
            end
            S_PUSH_LO: begin
                if (mem_ready_i) begin
                    r_d.sp = r_q.sp - 1'b1;
                    r_d.st = r_q.tbl ? S_RD_LO : S_DONE;
                end
            end
            S_RD_LO: begin
                if (mem_ready_i) begin
                    r_d.tgt[DW-1:0] = mem_rdata_i;
                    r_d.st          = S_RD_HI;
                end
            end
            S_RD_HI: begin
                if (mem_ready_i) begin
                    r_d.tgt[AW-1:DW] = mem_rdata_i;
                    r_d.st           = S_DONE;
                end
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        inta_o      = (r_q.st == S_ACK);
        mem_req_o   = (r_q.st == S_PUSH_HI) || (r_q.st == S_PUSH_LO) ||
                      (r_q.st == S_RD_LO)   || (r_q.st == S_RD_HI);
        mem_we_o    = (r_q.st == S_PUSH_HI) || (r_q.st == S_PUSH_LO);
        mem_wdata_o = (r_q.st == S_PUSH_HI) ? r_q.pc[AW-1:DW] : r_q.pc[DW-1:0];
        case (r_q.st)
            S_RD_LO: mem_addr_o = r_q.ptr;
            S_RD_HI: mem_addr_o = r_q.ptr + 1'b1;
            default: mem_addr_o = r_q.sp - 1'b1;
        endcase
        busy_o     = !idle;
        done_o     = (r_q.st == S_DONE);
        pc_o       = r_q.tgt;
        wz_o       = r_q.tgt;
        sp_o       = r_q.sp;
        iff_we_o   = r_q.iff_we;
        iff1_o     = 1'b0;
        iff2_o     = r_q.iff2;
        halt_clr_o = r_q.hclr;
        err_o      = done_o && r_q.err;
    end

    // R3
    nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && r_q.is_nmi) |-> (pc_o == NMI_VEC));

    // R2
    nmi_iff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iff_we_o && r_q.is_nmi) |-> (!iff1_o && iff2_o == $past(iff1_i)));

    // R5
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PUSH_HI && mem_ready_i) |=>
        (mem_req_o && mem_we_o && mem_addr_o == $past(mem_addr_o) - 1'b1 &&
         mem_wdata_o == $past(r_q.pc[DW-1:0])));

    // R8
    im0_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (pc_o == IM1_VEC && !r_q.is_nmi));

    // R4
    no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && boundary_i && !nmi_pend && !(int_req_i && iff1_i && !skip_int_i))
        |=> !busy_o);

    // R1
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && boundary_i && nmi_pend) |=> (busy_o && r_q.is_nmi && !inta_o));
endmodule

// File: tb/irq_resp_seq_test.sv
module irq_resp_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 0, skip_int_i = 0, nmi_i = 0, int_req_i = 0;
    logic [1:0]  int_mode_i = 0;
    logic        iff1_i = 0, halted_i = 0, ack_valid_i = 0;
    logic [7:0]  ireg_i = 0, ack_data_i = 0, mem_rdata_i, mem_wdata_o;
    logic [15:0] pc_i = 0, sp_i = 0, mem_addr_o, pc_o, wz_o, sp_o;
    logic        mem_ready_i = 1'b1;
    logic        inta_o, mem_req_o, mem_we_o, busy_o, done_o;
    logic        iff_we_o, iff1_o, iff2_o, halt_clr_o, err_o;

    int checks = 0, fails = 0, wcnt = 0;
    bit finished = 0;
    logic [15:0] waddr [0:7];
    logic [7:0]  wdata [0:7];

    always #2 clk = ~clk;

    irq_resp_seq uut (.*);

    function automatic logic [7:0] mf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign mem_rdata_i = mf(mem_addr_o);

    always @(negedge clk) mem_ready_i <= (($urandom % 4) != 0);

    always @(posedge clk)
        if (mem_req_o && mem_we_o && mem_ready_i && wcnt < 8) begin
            waddr[wcnt] <= mem_addr_o;
            wdata[wcnt] <= mem_wdata_o;
            wcnt <= wcnt + 1;
        end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_tgt(input bit nmi, input logic [1:0] mode,
                                            input logic [7:0] ireg, input logic [7:0] b);
        logic [15:0] p;
        if (nmi) return 16'h0066;
        if (mode == 2'b01) return 16'h0038;
        if (mode == 2'b00)
            return (b[7:6] == 2'b11 && b[2:0] == 3'b111) ? {10'd0, b[5:3], 3'd0} : 16'h0038;
        p = {ireg, b};
        return {mf(p + 16'd1), mf(p)};
    endfunction

    task automatic trial(input bit nmi, input int gap, input bit ireq, input bit iff1,
                         input bit skip, input bit halt, input logic [1:0] mode,
                         input logic [7:0] ireg, input bit aval, input logic [7:0] adat,
                         input logic [15:0] pc, input logic [15:0] sp);
        bit took_n, took_i, got;
        logic [7:0] b;
        logic [15:0] et;
        bit eerr;
        took_n = nmi;
        took_i = !nmi && ireq && iff1 && !skip;
        b      = aval ? adat : 8'h00;
        et     = exp_tgt(took_n, mode, ireg, b);
        eerr   = took_i && mode == 2'b00 && !(b[7:6] == 2'b11 && b[2:0] == 3'b111);
        if (nmi) begin
            @(negedge clk) nmi_i = 1'b1;
            @(negedge clk) nmi_i = 1'b0;
            repeat (gap) @(negedge clk);
        end else @(negedge clk);
        wcnt = 0;
        int_req_i = ireq; iff1_i = iff1; skip_int_i = skip; halted_i = halt;
        int_mode_i = mode; ireg_i = ireg; ack_valid_i = aval; ack_data_i = adat;
        pc_i = pc; sp_i = sp; boundary_i = 1'b1;
        @(negedge clk) boundary_i = 1'b0;
        chk(iff_we_o == (took_n || took_i), "R2 iff_we", iff_we_o, took_n || took_i);
        if (took_n || took_i) begin
            chk(!iff1_o && iff2_o == (took_n ? iff1 : 1'b0), "R2 iff2", iff2_o, took_n ? iff1 : 1'b0);
            chk(halt_clr_o == halt, "R10 halt_clr", halt_clr_o, halt);
            chk(inta_o == took_i, "R11 inta", inta_o, took_i);
            got = 0;
            for (int k = 0; k < 60 && !got; k++) begin
                if (done_o) got = 1;
                else @(negedge clk);
            end
            chk(got, "R1 done seen", got, 1);
            if (got) begin
                chk(pc_o == et, nmi ? "R3 nmi pc" : (mode == 2'b01 ? "R6 im1 pc" :
                    (mode == 2'b00 ? "R8 im0 pc" : "R7 im2 pc")), pc_o, et);
                chk(wz_o == pc_o, "R9 wz", wz_o, pc_o);
                chk(err_o == eerr, "R8 err", err_o, eerr);
                chk(sp_o == sp - 16'd2, "R5 sp", sp_o, sp - 16'd2);
                chk(wcnt == 2, "R5 write count", wcnt, 2);
                chk(waddr[0] == sp - 16'd1 && wdata[0] == pc[15:8], "R5 first write",
                    {waddr[0], wdata[0]}, {sp - 16'd1, pc[15:8]});
                chk(waddr[1] == sp - 16'd2 && wdata[1] == pc[7:0], "R5 second write",
                    {waddr[1], wdata[1]}, {sp - 16'd2, pc[7:0]});
            end
            @(negedge clk);
        end else begin
            got = 0;
            for (int k = 0; k < 8; k++) begin
                if (done_o || mem_req_o || inta_o || busy_o) got = 1;
                @(negedge clk);
            end
            chk(!got, "R4 not taken", got, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !mem_req_o && !done_o && !iff_we_o, "R4 reset idle",
            {busy_o, mem_req_o, done_o, iff_we_o}, 0);
        // R1 NMI beats INT at the same boundary; held across a gap
        trial(1, 0, 1, 1, 0, 0, 2'b01, 8'h00, 0, 8'h00, 16'h1234, 16'h8000);
        trial(1, 6, 1, 0, 0, 1, 2'b10, 8'h12, 1, 8'h34, 16'hBEEF, 16'h4000);
        // R1 pending cleared after it was taken
        trial(0, 0, 0, 1, 0, 0, 2'b01, 8'h00, 0, 8'h00, 16'h0100, 16'h2000);
        // R6, R10 mode 1 waking the core
        trial(0, 0, 1, 1, 0, 1, 2'b01, 8'h00, 0, 8'h00, 16'hABCD, 16'hFF00);
        // R8 restart opcodes and a bad opcode
        trial(0, 0, 1, 1, 0, 0, 2'b00, 8'h00, 1, 8'hFF, 16'h0203, 16'h9000);
        trial(0, 0, 1, 1, 0, 0, 2'b00, 8'h00, 1, 8'hC7, 16'h0405, 16'h9000);
        trial(0, 0, 1, 1, 0, 0, 2'b00, 8'h00, 1, 8'hEF, 16'h0607, 16'h9000);
        trial(0, 0, 1, 1, 0, 0, 2'b00, 8'h00, 1, 8'hC3, 16'h0809, 16'h9000);
        // R7 no device byte, pointer carry, mode 3 as table
        trial(0, 0, 1, 1, 0, 0, 2'b10, 8'h3F, 0, 8'hAA, 16'h1111, 16'h7000);
        trial(0, 0, 1, 1, 0, 0, 2'b11, 8'h20, 1, 8'hFF, 16'h2222, 16'h7000);
        // R5 stack wrap
        trial(0, 0, 1, 1, 0, 0, 2'b01, 8'h00, 0, 8'h00, 16'h3344, 16'h0001);
        // R4 refusals
        trial(0, 0, 1, 1, 1, 0, 2'b01, 8'h00, 0, 8'h00, 16'h5555, 16'h6000);
        trial(0, 0, 1, 0, 0, 1, 2'b10, 8'h00, 0, 8'h00, 16'h5555, 16'h6000);
        for (int n = 0; n < 60; n++) begin
            trial(($urandom % 4) == 0, $urandom % 3, $urandom % 2, ($urandom % 4) != 0,
                  ($urandom % 5) == 0, $urandom % 2, 2'($urandom), 8'($urandom),
                  ($urandom % 4) != 0, 8'($urandom), 16'($urandom), 16'($urandom));
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule